// File: doc/BRIEF.md
# Interrupt-Gated Staged Command Sequencer

This block takes one command byte at a time from a host and carries it out as a series of numbered stages. A tick-based delay separates every stage, and the delay counts down only on cycles where the elapsed-tick input is high. When a stage finishes, the sequencer does one of three things. It can end the command. It can arm the next delay at once. Or it can park until the host has acknowledged every pending interrupt flag, and only then start the next countdown.

Each stage that runs pushes a burst of response bytes in a single cycle, writes an interrupt code into a small flag register, and updates a drive status byte. Around each command the block also does queue housekeeping. It pulses a response-queue clear when it accepts a command and a parameter-queue clear when the command ends. It drives one-cycle strobes that start and stop a sector reader kept outside the block.

Top module: `cmd_stage_seq`

## Requirements
- R1: After reset, busy_o is 0, irq_flag_o is 0, drive_stat_o is 0 and no output strobe is high.
- R2: A command write while busy_o is 0 is accepted. In the next cycle busy_o is 1 and resp_clr_o pulses for one cycle.
- R3: A command write while busy_o is 1 is ignored. No resp_clr_o pulse follows, and the running command's responses and timing are unchanged.
- R4: Each stage runs on the Nth tick_i cycle after its delay is armed, where N is CMD_DLY for stage 0, SEEK_DLY after a non-waiting advance, and STAGE_DLY after an interrupt wait. Ticks in the arming cycle do not count.
- R5: Every stage that runs pushes its response bytes (resp_data_o byte i at bits 8i+7..8i, byte 0 first, resp_cnt_o valid bytes, the rest zero) and in the same cycle sets irq_flag_o to its code: 2 for completion, 3 for acknowledge, 5 for fault.
- R6: When a command ends, busy_o falls and param_clr_o pulses in the same cycle as the final push.
- R7: While waiting for interrupt acknowledgement, no stage runs and the countdown is held, whatever tick_i does.
- R8: An acknowledge write clears the flag bits set in ack_mask_i. A write that leaves the flags non-zero keeps the wait. A write that leaves them zero arms the next delay.
- R9: Status query (0x01) pushes the status byte, posts code 3, and ends. Status bits: 1 motor on, 5 reading, 6 seeking.
- R10: Pause (0x09) stage 0 pushes the status byte as it was, posts 3, clears the reading bit, pulses read_stop_o if reading was set, and waits. Stage 1 pushes the status byte, posts 2, and ends.
- R11: Seek (0x15) stage 0 clears reading (pulsing read_stop_o if it was set), sets motor and seeking, pushes the new byte, posts 3, and advances without waiting. Stage 1 clears seeking, pushes the byte, posts 2, and ends.
- R12: Identify (0x1A) with disc_i low pushes 0x11 then 0x80, posts 5, and ends. With disc_i high, stage 0 pushes the status byte, posts 3, and waits. Stage 1 pushes the 8 ID_BYTES bytes, posts 2, and ends.
- R13: Read (0x06) pulses read_start_o, pulses read_stop_o if reading was set, sets motor and reading, clears seeking, pushes the new byte, posts 3, and ends.
- R14: Any other command byte pushes the status byte with bit 0 set, posts 5, and ends. The stored status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One elapsed tick this cycle |
| cmd_wr_i | input | 1 | Command byte write strobe |
| cmd_i | input | 8 | Command byte |
| ack_wr_i | input | 1 | Interrupt acknowledge write strobe |
| ack_mask_i | input | 3 | Flag bits to clear |
| disc_i | input | 1 | Disc present |
| busy_o | output | 1 | A command is in progress |
| irq_flag_o | output | 3 | Pending interrupt code (0 = none) |
| resp_clr_o | output | 1 | Clear the response queue |
| resp_push_o | output | 1 | Push a response burst |
| resp_cnt_o | output | 4 | Bytes in the burst |
| resp_data_o | output | 64 | Burst bytes, byte 0 in the low bits |
| param_clr_o | output | 1 | Clear the parameter queue |
| read_start_o | output | 1 | Start-reading strobe |
| read_stop_o | output | 1 | Stop-reading strobe |
| drive_stat_o | output | 8 | Drive status byte |

## Verification
Acceptance is due one cycle after the write: busy_o is 1 and resp_clr_o pulses at the next edge. A stage's push, flag code, status update, strobes and any end-of-command clear all show up together at the edge that follows the Nth counted tick. The bench therefore counts the ticks it drives from the cycle after the arming event and samples just after each edge. When it sees a push, it checks that the count is exactly the expected delay. Acknowledge results are checked one cycle after the write. During interrupt waits the bench drives dense ticks and confirms that nothing is pushed.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_IRQ  = 2'd2
    } sq_state_e;

    typedef enum logic [1:0] {
        NX_END  = 2'd0,
        NX_WAIT = 2'd1,
        NX_GO   = 2'd2
    } nx_kind_e;

    localparam logic [7:0] OP_STATUS = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h06;
    localparam logic [7:0] OP_PAUSE  = 8'h09;
    localparam logic [7:0] OP_SEEK   = 8'h15;
    localparam logic [7:0] OP_IDENT  = 8'h1A;

    localparam logic [2:0] IRQ_DONE  = 3'd2;
    localparam logic [2:0] IRQ_ACK   = 3'd3;
    localparam logic [2:0] IRQ_FAULT = 3'd5;

    localparam int BIT_ERR   = 0;
    localparam int BIT_MOTOR = 1;
    localparam int BIT_READ  = 5;
    localparam int BIT_SEEK  = 6;

    localparam int RESP_BYTES = 8;
    localparam int RESP_W     = 8 * RESP_BYTES;
    localparam int RESP_CW    = $clog2(RESP_BYTES + 1);

    typedef struct packed {
        logic [RESP_CW-1:0] cnt;
        logic [RESP_W-1:0]  data;
        logic [2:0]         code;
        nx_kind_e           nxt;
        logic               seek_dly;
        logic [7:0]         stat;
        logic               rd_start;
        logic               rd_stop;
    } stage_act_t;

    function automatic logic [RESP_W-1:0] pack_one(input logic [7:0] b);
        return {{(RESP_W-8){1'b0}}, b};
    endfunction

endpackage

// File: rtl/cmd_seq_delay.sv
module cmd_seq_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clr_i,
    output logic         expire_o
);
    logic [W-1:0] rem_q;

    assign expire_o = en_i && tick_i && (rem_q <= W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (clr_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (en_i && tick_i && rem_q != '0) begin
            rem_q <= rem_q - W'(1);
        end
    end

    // R4: the count moves only on an enabled tick, a load or a clear
    p_hold_count_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !clr_i && !(en_i && tick_i)) |=> $stable(rem_q));

endmodule

// File: rtl/cmd_seq_irq_flags.sv
module cmd_seq_irq_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       post_i,
    input  logic [2:0] code_i,
    input  logic       ack_wr_i,
    input  logic [2:0] ack_mask_i,
    output logic [2:0] flag_o,
    output logic       ack_zero_o
);
    logic [2:0] flag_q;

    assign flag_o     = flag_q;
    assign ack_zero_o = ack_wr_i && ((flag_q & ~ack_mask_i) == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 3'd0;
        end else if (post_i) begin
            flag_q <= code_i;
        end else if (ack_wr_i) begin
            flag_q <= flag_q & ~ack_mask_i;
        end
    end

    // R8: acknowledge clears exactly the masked bits
    p_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_wr_i && !post_i) |=> flag_q == ($past(flag_q) & ~$past(ack_mask_i)));

endmodule

// File: rtl/cmd_seq_stage_exec.sv
module cmd_seq_stage_exec
    import cmd_seq_pkg::*;
#(
    parameter int                STG_W    = 2,
    parameter logic [RESP_W-1:0] ID_BYTES = '0
) (
    input  logic [7:0]       op_i,
    input  logic [STG_W-1:0] stage_i,
    input  logic             disc_i,
    input  logic [7:0]       stat_i,
    output stage_act_t       act_o
);
    logic first;
    logic was_rd;

    assign first  = (stage_i == '0);
    assign was_rd = stat_i[BIT_READ];

    always_comb begin
        act_o          = '0;
        act_o.cnt      = RESP_CW'(1);
        act_o.data     = pack_one(stat_i);
        act_o.code     = IRQ_ACK;
        act_o.nxt      = NX_END;
        act_o.stat     = stat_i;
        unique case (op_i)
            OP_STATUS: begin
            end
            OP_READ: begin
                act_o.stat           = stat_i;
                act_o.stat[BIT_MOTOR] = 1'b1;
                act_o.stat[BIT_READ]  = 1'b1;
                act_o.stat[BIT_SEEK]  = 1'b0;
                act_o.rd_start       = 1'b1;
                act_o.rd_stop        = was_rd;
                act_o.data           = pack_one(act_o.stat);
            end
            OP_PAUSE: begin
                if (first) begin
                    act_o.stat[BIT_READ] = 1'b0;
                    act_o.rd_stop        = was_rd;
                    act_o.nxt            = NX_WAIT;
                end else begin
                    act_o.code = IRQ_DONE;
                end
            end
            OP_SEEK: begin
                if (first) begin
                    act_o.stat[BIT_READ]  = 1'b0;
                    act_o.stat[BIT_MOTOR] = 1'b1;
                    act_o.stat[BIT_SEEK]  = 1'b1;
                    act_o.rd_stop         = was_rd;
                    act_o.nxt             = NX_GO;
                    act_o.seek_dly        = 1'b1;
                end else begin
                    act_o.stat[BIT_SEEK] = 1'b0;
                    act_o.code           = IRQ_DONE;
                end
                act_o.data = pack_one(act_o.stat);
            end
            OP_IDENT: begin
                if (first && !disc_i) begin
                    act_o.cnt  = RESP_CW'(2);
                    act_o.data = {{(RESP_W-16){1'b0}}, 8'h80, 8'h11};
                    act_o.code = IRQ_FAULT;
                end else if (first) begin
                    act_o.nxt = NX_WAIT;
                end else begin
                    act_o.cnt  = RESP_CW'(RESP_BYTES);
                    act_o.data = ID_BYTES;
                    act_o.code = IRQ_DONE;
                end
            end
            default: begin
                act_o.data = pack_one(stat_i | 8'(1 << BIT_ERR));
                act_o.code = IRQ_FAULT;
            end
        endcase
    end

endmodule

// File: rtl/cmd_stage_seq.sv
module cmd_stage_seq
    import cmd_seq_pkg::*;
#(
    parameter int                DLY_W     = 8,
    parameter int                CMD_DLY   = 100,
    parameter int                STAGE_DLY = 100,
    parameter int                SEEK_DLY  = 100,
    parameter int                STG_W     = 2,
    parameter logic [RESP_W-1:0] ID_BYTES  = 64'h4B52_4443_0020_0002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cmd_wr_i,
    input  logic [7:0]        cmd_i,
    input  logic              ack_wr_i,
    input  logic [2:0]        ack_mask_i,
    input  logic              disc_i,
    output logic              busy_o,
    output logic [2:0]        irq_flag_o,
    output logic              resp_clr_o,
    output logic              resp_push_o,
    output logic [RESP_CW-1:0] resp_cnt_o,
    output logic [RESP_W-1:0] resp_data_o,
    output logic              param_clr_o,
    output logic              read_start_o,
    output logic              read_stop_o,
    output logic [7:0]        drive_stat_o
);
    localparam logic [DLY_W-1:0] CMD_DLY_V   = DLY_W'(CMD_DLY);
    localparam logic [DLY_W-1:0] STAGE_DLY_V = DLY_W'(STAGE_DLY);
    localparam logic [DLY_W-1:0] SEEK_DLY_V  = DLY_W'(SEEK_DLY);

    sq_state_e        state_q;
    logic [7:0]       op_q;
    logic [STG_W-1:0] stage_q;
    logic [7:0]       stat_q;
    stage_act_t       act;
    logic             accept;
    logic             expire;
    logic             ack_zero;
    logic             dly_load;
    logic             dly_clr;
    logic [DLY_W-1:0] dly_val;

    assign accept  = (state_q == SQ_IDLE) && cmd_wr_i;
    assign dly_clr = expire && (act.nxt == NX_END);
    assign dly_load = accept || (expire && act.nxt != NX_END);
    assign dly_val = accept       ? CMD_DLY_V  :
                     act.seek_dly ? SEEK_DLY_V : STAGE_DLY_V;

    assign busy_o       = (state_q != SQ_IDLE);
    assign drive_stat_o = stat_q;

    cmd_seq_stage_exec #(.STG_W(STG_W), .ID_BYTES(ID_BYTES)) exec_i (
        .op_i   (op_q),
        .stage_i(stage_q),
        .disc_i (disc_i),
        .stat_i (stat_q),
        .act_o  (act)
    );

    cmd_seq_delay #(.W(DLY_W)) delay_i (
        .clk       (clk),
        .rst       (rst),
        .en_i      (state_q == SQ_RUN),
        .tick_i    (tick_i),
        .load_i    (dly_load),
        .load_val_i(dly_val),
        .clr_i     (dly_clr),
        .expire_o  (expire)
    );

    cmd_seq_irq_flags flags_i (
        .clk       (clk),
        .rst       (rst),
        .post_i    (expire),
        .code_i    (act.code),
        .ack_wr_i  (ack_wr_i),
        .ack_mask_i(ack_mask_i),
        .flag_o    (irq_flag_o),
        .ack_zero_o(ack_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            op_q         <= '0;
            stage_q      <= '0;
            stat_q       <= '0;
            resp_clr_o   <= 1'b0;
            resp_push_o  <= 1'b0;
            resp_cnt_o   <= '0;
            resp_data_o  <= '0;
            param_clr_o  <= 1'b0;
            read_start_o <= 1'b0;
            read_stop_o  <= 1'b0;
        end else begin
            resp_clr_o   <= 1'b0;
            resp_push_o  <= 1'b0;
            param_clr_o  <= 1'b0;
            read_start_o <= 1'b0;
            read_stop_o  <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cmd_wr_i) begin
                        op_q       <= cmd_i;
                        stage_q    <= '0;
                        resp_clr_o <= 1'b1;
                        state_q    <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (expire) begin
                        resp_push_o  <= 1'b1;
                        resp_cnt_o   <= act.cnt;
                        resp_data_o  <= act.data;
                        stat_q       <= act.stat;
                        read_start_o <= act.rd_start;
                        read_stop_o  <= act.rd_stop;
                        unique case (act.nxt)
                            NX_END: begin
                                state_q     <= SQ_IDLE;
                                stage_q     <= '0;
                                param_clr_o <= 1'b1;
                            end
                            NX_WAIT: begin
                                stage_q <= stage_q + STG_W'(1);
                                state_q <= SQ_IRQ;
                            end
                            default: begin
                                stage_q <= stage_q + STG_W'(1);
                            end
                        endcase
                    end
                end
                SQ_IRQ: begin
                    if (ack_zero) state_q <= SQ_RUN;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R2: an idle write is taken and clears the response queue
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && cmd_wr_i) |=> (busy_o && resp_clr_o));

    // R3: a write while busy leaves no clear behind
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cmd_wr_i) |=> !resp_clr_o);

    // R5: every push carries a valid interrupt code
    p_post_code_r5: assert property (@(posedge clk) disable iff (rst)
        resp_push_o |-> (irq_flag_o >= 3'd1 && irq_flag_o <= 3'd5));

    // R6: end of command clears the parameter queue
    p_end_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (param_clr_o && resp_push_o));

    // R7: no stage runs while flags are pending acknowledgement
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IRQ && !ack_zero) |=> (state_q == SQ_IRQ && !resp_push_o));

    // R13: a read start always leaves the reading bit set
    p_read_start_r13: assert property (@(posedge clk) disable iff (rst)
        read_start_o |-> drive_stat_o[BIT_READ]);

endmodule

// File: tb/cmd_stage_seq_tb_top.sv
module cmd_stage_seq_tb_top;
    localparam int          CMD_DLY   = 100;
    localparam int          STAGE_DLY = 100;
    localparam int          SEEK_DLY  = 100;
    localparam logic [63:0] ID_BYTES  = 64'h4B52_4443_0020_0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        cmd_wr_i = 1'b0;
    logic [7:0]  cmd_i = 8'h00;
    logic        ack_wr_i = 1'b0;
    logic [2:0]  ack_mask_i = 3'd0;
    logic        disc_i = 1'b0;
    logic        busy_o;
    logic [2:0]  irq_flag_o;
    logic        resp_clr_o;
    logic        resp_push_o;
    logic [3:0]  resp_cnt_o;
    logic [63:0] resp_data_o;
    logic        param_clr_o;
    logic        read_start_o;
    logic        read_stop_o;
    logic [7:0]  drive_stat_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] mstat = 8'h00;

    always #10 clk = ~clk;

    cmd_stage_seq dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
        .ack_wr_i(ack_wr_i), .ack_mask_i(ack_mask_i), .disc_i(disc_i),
        .busy_o(busy_o), .irq_flag_o(irq_flag_o), .resp_clr_o(resp_clr_o),
        .resp_push_o(resp_push_o), .resp_cnt_o(resp_cnt_o), .resp_data_o(resp_data_o),
        .param_clr_o(param_clr_o), .read_start_o(read_start_o), .read_stop_o(read_stop_o),
        .drive_stat_o(drive_stat_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    typedef struct packed {
        logic [3:0]  cnt;
        logic [63:0] data;
        logic [2:0]  code;
        logic [1:0]  kind;   // 0 end, 1 wait, 2 go
        logic [7:0]  stat;
        logic        rs;
        logic        rp;
    } exp_t;

    function automatic exp_t expect_stage(input logic [7:0] op, input int stg,
                                          input logic disc, input logic [7:0] st);
        exp_t e;
        e = '0;
        e.cnt = 4'd1; e.code = 3'd3; e.stat = st; e.data = {56'd0, st};
        case (op)
            8'h01: ;
            8'h06: begin
                e.stat = (st | 8'h22) & ~8'h40;
                e.rs = 1'b1; e.rp = st[5];
                e.data = {56'd0, e.stat};
            end
            8'h09: begin
                if (stg == 0) begin
                    e.stat = st & ~8'h20; e.rp = st[5]; e.kind = 2'd1;
                end else e.code = 3'd2;
            end
            8'h15: begin
                if (stg == 0) begin
                    e.stat = (st & ~8'h20) | 8'h42; e.rp = st[5]; e.kind = 2'd2;
                end else begin
                    e.stat = st & ~8'h40; e.code = 3'd2;
                end
                e.data = {56'd0, e.stat};
            end
            8'h1A: begin
                if (stg == 0 && !disc) begin
                    e.cnt = 4'd2; e.data = 64'h8011; e.code = 3'd5;
                end else if (stg == 0) e.kind = 2'd1;
                else begin
                    e.cnt = 4'd8; e.data = ID_BYTES; e.code = 3'd2;
                end
            end
            default: begin
                e.data = {56'd0, st | 8'h01}; e.code = 3'd5;
            end
        endcase
        return e;
    endfunction

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'h01: return "R9";
            8'h06: return "R13";
            8'h09: return "R10";
            8'h15: return "R11";
            8'h1A: return "R12";
            default: return "R14";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic cw, input logic [7:0] c,
                        input logic aw, input logic [2:0] am);
        @(negedge clk);
        tick_i = tk; cmd_wr_i = cw; cmd_i = c; ack_wr_i = aw; ack_mask_i = am;
        @(posedge clk);
        #1;
    endtask

    function automatic logic rtick();
        return ($urandom_range(0, 9) < 7);
    endfunction

    task automatic wait_push(input int exp_ticks, output bit ok);
        int cnt;
        cnt = 0;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            logic tk;
            logic inj;
            tk  = rtick();
            inj = ($urandom_range(0, 24) == 0);
            step(tk, inj, 8'($urandom_range(0, 255)), 1'b0, 3'd0);
            if (tk) cnt++;
            if (inj) chk("R3 busy write cleared queue", 64'(resp_clr_o), 64'd0);
            if (resp_push_o) begin
                chk("R4 ticks to stage", 64'(cnt), 64'(exp_ticks));
                ok = 1;
                return;
            end
        end
        chk("R4 stage never ran", 64'd0, 64'd1);
    endtask

    task automatic run_cmd(input logic [7:0] op);
        exp_t  e;
        bit    ok;
        int    dly;
        string tg;
        tg = op_tag(op);
        step(rtick(), 1'b1, op, 1'b0, 3'd0);
        chk("R2 busy after accept", 64'(busy_o), 64'd1);
        chk("R2 response clear pulse", 64'(resp_clr_o), 64'd1);
        dly = CMD_DLY;
        for (int stg = 0; stg < 3; stg++) begin
            wait_push(dly, ok);
            if (!ok) return;
            e = expect_stage(op, stg, disc_i, mstat);
            chk({tg, " R5 count"}, 64'(resp_cnt_o), 64'(e.cnt));
            chk({tg, " R5 data"}, resp_data_o, e.data);
            chk({tg, " R5 irq code"}, 64'(irq_flag_o), 64'(e.code));
            chk({tg, " status"}, 64'(drive_stat_o), 64'(e.stat));
            chk({tg, " read strobes"}, {62'd0, read_start_o, read_stop_o}, {62'd0, e.rs, e.rp});
            mstat = e.stat;
            if (e.kind == 2'd0) begin
                chk("R6 busy falls at end", 64'(busy_o), 64'd0);
                chk("R6 parameter clear", 64'(param_clr_o), 64'd1);
                break;
            end else if (e.kind == 2'd1) begin
                chk("R7 busy during wait", 64'(busy_o), 64'd1);
                for (int k = 0; k < 130; k++) begin
                    step(1'b1, 1'b0, 8'h00, 1'b0, 3'd0);
                    if (resp_push_o) chk("R7 stage ran before ack", 64'd1, 64'd0);
                end
                step(rtick(), 1'b0, 8'h00, 1'b1, 3'b001);
                chk("R8 partial ack", 64'(irq_flag_o), 64'd2);
                for (int k = 0; k < 40; k++) begin
                    step(1'b1, 1'b0, 8'h00, 1'b0, 3'd0);
                    if (resp_push_o) chk("R8 ran with flags left", 64'd1, 64'd0);
                end
                step(rtick(), 1'b0, 8'h00, 1'b1, 3'b010);
                chk("R8 full ack", 64'(irq_flag_o), 64'd0);
                dly = STAGE_DLY;
            end else begin
                dly = SEEK_DLY;
            end
        end
        step(rtick(), 1'b0, 8'h00, 1'b1, 3'b111);
        chk("R8 flags cleared after command", 64'(irq_flag_o), 64'd0);
    endtask

    initial begin
        logic [7:0] ops [6];
        void'($urandom(32'd20240917));
        ops[0] = 8'h01; ops[1] = 8'h06; ops[2] = 8'h09;
        ops[3] = 8'h15; ops[4] = 8'h1A; ops[5] = 8'h3C;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 busy after reset", 64'(busy_o), 64'd0);
        chk("R1 flags after reset", 64'(irq_flag_o), 64'd0);
        chk("R1 status after reset", 64'(drive_stat_o), 64'd0);
        chk("R1 strobes after reset",
            {59'd0, resp_push_o, resp_clr_o, param_clr_o, read_start_o, read_stop_o}, 64'd0);

        // directed corners
        run_cmd(8'h01);
        disc_i = 1'b0; run_cmd(8'h1A);
        disc_i = 1'b1; run_cmd(8'h1A);
        run_cmd(8'h06);
        run_cmd(8'h15);
        run_cmd(8'h06);
        run_cmd(8'h09);
        run_cmd(8'h09);
        run_cmd(8'h77);

        // constrained random mix
        for (int n = 0; n < 24; n++) begin
            disc_i = 1'($urandom_range(0, 1));
            run_cmd(ops[$urandom_range(0, 5)]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule